// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a CPU data-memory port to an external SRAM through an 8-bit bus that carries the low address byte first and then the data. The high address byte has its own pins. Each CPU request is compared with a programmable internal-memory boundary. An address above the boundary goes to the external device. Any other address goes to internal SRAM through a simple select port.

For an external access the controller runs four steps. It drives the address and raises the address-latch enable for one cycle. It then drops the enable while it keeps the low address on the bus, so that an external transparent latch holds the address. Next it asserts the active-low read or write strobe for one cycle plus a programmed number of wait cycles. Finally it releases the bus and pulses ready to the CPU.

While enabled, the controller owns the shared bus, the control pins and a programmable number of high-address pins. It overrides the general-purpose port direction and value for those pins. The high-address pins it does not own, and every pin when it is disabled, follow the port settings.

Top module: `xbus_ctrl`

## Requirements
- R1: Reset clears the enable bit. After reset, cpu_ready is low and every pad output and output-enable equals its general-purpose port setting.
- R2: While disabled, the pins follow the port settings:
  - pad_ad_oe/pad_ad_out equal gpio_dir_ad/gpio_out_ad.
  - pad_hi_oe/pad_hi_out equal gpio_dir_hi/gpio_out_hi.
  - pad_ctl_oe equals gpio_dir_ctl.
  - {pad_wr_n, pad_rd_n, pad_ale} equals gpio_out_ctl, where bit 0 is ALE, bit 1 is RD and bit 2 is WR.
- R3: An address strictly greater than the boundary is external. An address equal to or below the boundary is internal.
- R4: An access while enabled starts with one cycle in which pad_ale is high, AD carries the low address byte and the high pins carry the high byte. In the next cycle pad_ale is low and AD still drives the same low address.
- R5: An external access asserts exactly one active-low strobe for wait+1 cycles, with wait in 0..3. No strobe is low while ALE is high, and the two strobes are never low together.
- R6: During an external write, AD drives the write data while pad_wr_n is low. The latched address equals the CPU address.
- R7: During an external read, AD is released while pad_rd_n is low. The value on pad_ad_in in the last strobe cycle is returned on cpu_rdata with ready.
- R8: cpu_ready is a one-cycle pulse. While enabled, it comes wait+4 cycles after the accepting edge for an external access and 4 cycles after it for an internal access.
- R9: An internal access while enabled pulses ALE and drives AD, but never strobes. int_sel is high for one cycle, and during that cycle AD shows the write data or int_rdata.
- R10: While disabled, an address above the boundary reaches neither internal SRAM nor the strobes. It completes one cycle after acceptance with cpu_rdata equal to 0.
- R11: While disabled, an internal access raises int_sel for one cycle and completes two cycles after acceptance.
- R12: With high-bit count k (values above 8 clamp to 8), the high pins [k-1:0] carry the address while enabled. The remaining high pins follow the port settings.
- R13: A request that arrives while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load the configuration fields |
| cfg_en | input | 1 | Enable value to load |
| cfg_hi_bits | input | 4 | Number of high address pins to own |
| cfg_wait | input | 2 | Wait cycles added to the strobe |
| cfg_bound | input | 16 | Highest internal address |
| cpu_req | input | 1 | Access request, taken when idle |
| cpu_we | input | 1 | 1 = write |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write data |
| cpu_ready | output | 1 | Access-complete pulse |
| cpu_rdata | output | 8 | Read data |
| int_sel | output | 1 | Internal SRAM select |
| int_we | output | 1 | Internal write enable |
| int_addr | output | 16 | Internal address |
| int_wdata | output | 8 | Internal write data |
| int_rdata | input | 8 | Internal read data |
| gpio_dir_ad | input | 8 | Port direction for the AD pins |
| gpio_out_ad | input | 8 | Port value for the AD pins |
| gpio_dir_hi | input | 8 | Port direction for the high pins |
| gpio_out_hi | input | 8 | Port value for the high pins |
| gpio_dir_ctl | input | 3 | Port direction for the ALE/RD/WR pins |
| gpio_out_ctl | input | 3 | Port value for the ALE/RD/WR pins |
| pad_ad_in | input | 8 | AD pin input |
| pad_ad_out | output | 8 | AD pin output value |
| pad_ad_oe | output | 8 | AD pin output enable |
| pad_hi_out | output | 8 | High pin output value |
| pad_hi_oe | output | 8 | High pin output enable |
| pad_ale | output | 1 | Address latch enable |
| pad_rd_n | output | 1 | Read strobe, active low |
| pad_wr_n | output | 1 | Write strobe, active low |
| pad_ctl_oe | output | 3 | Control pin output enables |

## Verification
The assertions check the pin protocol on every cycle:
- no strobe while ALE is high, and never both strobes at once;
- the bus is still driven and unchanged in the cycle after ALE falls;
- no strobe during an internal select;
- a one-cycle ready and a one-cycle internal select;
- the port settings on all pins while the block is disabled.

The bench scenarios cover what depends on values and counts: the latency for each wait count, the read and write data, the boundary classification including the equal case, the split of high-pin ownership for each bit count, and a request that is dropped during a busy access.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_STRB,
        ST_DONE
    } xbus_state_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_INT,
        ACC_EXT
    } acc_kind_e;

    typedef struct packed {
        logic wr_n;
        logic rd_n;
        logic ale;
    } ctl_pins_t;

    // Above the boundary: external when enabled, unmapped when disabled.
    function automatic acc_kind_e classify(input logic en, input logic above);
        if (above) begin
            return en ? ACC_EXT : ACC_NONE;
        end
        return ACC_INT;
    endfunction

endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg #(
    parameter int AW        = 16,
    parameter int HW        = 8,
    parameter int HBW       = 4,
    parameter int WSW       = 2,
    parameter int BOUND_RST = 'h21FF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_wr,
    input  logic           cfg_en_i,
    input  logic [HBW-1:0] cfg_hi_i,
    input  logic [WSW-1:0] cfg_wait_i,
    input  logic [AW-1:0]  cfg_bound_i,
    output logic           en_q,
    output logic [HBW-1:0] hi_q,
    output logic [WSW-1:0] wait_q,
    output logic [AW-1:0]  bound_q
);
    localparam logic [HBW-1:0] HI_MAX = HBW'(HW);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            hi_q    <= HI_MAX;
            wait_q  <= '0;
            bound_q <= AW'(BOUND_RST);
        end else if (cfg_wr) begin
            en_q    <= cfg_en_i;
            hi_q    <= (cfg_hi_i > HI_MAX) ? HI_MAX : cfg_hi_i;
            wait_q  <= cfg_wait_i;
            bound_q <= cfg_bound_i;
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int WSW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WSW-1:0]   wait_n,
    input  logic [AW-1:0]    bound,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             cpu_ready,
    output logic [DW-1:0]    cpu_rdata,
    input  logic [DW-1:0]    pad_ad_in,
    input  logic [DW-1:0]    int_rdata,
    output ctl_pins_t        ctl,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic [AW-DW-1:0] hi_addr,
    output logic             int_sel,
    output logic             int_we,
    output logic [AW-1:0]    int_addr,
    output logic [DW-1:0]    int_wdata
);
    xbus_state_e    state;
    acc_kind_e      kind_q;
    acc_kind_e      kind_new;
    logic           we_q;
    logic           bus_en_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    logic [DW-1:0]  rdata_q;
    logic [WSW-1:0] wcnt;

    assign kind_new = classify(en, cpu_addr > bound);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind_q   <= ACC_NONE;
            we_q     <= 1'b0;
            bus_en_q <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            wcnt     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cpu_req) begin
                        kind_q   <= kind_new;
                        we_q     <= cpu_we;
                        addr_q   <= cpu_addr;
                        wdata_q  <= cpu_wdata;
                        bus_en_q <= en;
                        wcnt     <= (kind_new == ACC_EXT) ? wait_n : '0;
                        if (kind_new == ACC_NONE) begin
                            rdata_q <= '0;
                        end
                        if (en) begin
                            state <= ST_ADDR;
                        end else if (kind_new == ACC_INT) begin
                            state <= ST_STRB;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                ST_ADDR: state <= ST_HOLD;
                ST_HOLD: state <= ST_STRB;
                ST_STRB: begin
                    if (wcnt == '0) begin
                        if (!we_q) begin
                            rdata_q <= (kind_q == ACC_EXT) ? pad_ad_in : int_rdata;
                        end
                        state <= ST_DONE;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    logic in_addr, in_strb, ext_strb;
    assign in_addr  = (state == ST_ADDR) || (state == ST_HOLD);
    assign in_strb  = (state == ST_STRB);
    assign ext_strb = in_strb && (kind_q == ACC_EXT);

    always_comb begin
        ctl.ale  = (state == ST_ADDR) && bus_en_q;
        ctl.rd_n = !(ext_strb && !we_q);
        ctl.wr_n = !(ext_strb && we_q);
        ad_oe    = bus_en_q && (in_addr || (in_strb && (we_q || kind_q == ACC_INT)));
        if (in_addr) begin
            ad_out = addr_q[DW-1:0];
        end else if (we_q) begin
            ad_out = wdata_q;
        end else begin
            ad_out = int_rdata;
        end
    end

    assign hi_addr   = addr_q[AW-1:DW];
    assign int_sel   = in_strb && (kind_q == ACC_INT);
    assign int_we    = we_q;
    assign int_addr  = addr_q;
    assign int_wdata = wdata_q;
    assign cpu_ready = (state == ST_DONE);
    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux
    import xbus_pkg::*;
#(
    parameter int DW  = 8,
    parameter int HW  = 8,
    parameter int HBW = 4
) (
    input  logic           en,
    input  logic [HBW-1:0] hi_bits,
    input  logic [DW-1:0]  seq_ad_out,
    input  logic           seq_ad_oe,
    input  logic [HW-1:0]  seq_hi,
    input  ctl_pins_t      seq_ctl,
    input  logic [DW-1:0]  gpio_dir_ad,
    input  logic [DW-1:0]  gpio_out_ad,
    input  logic [HW-1:0]  gpio_dir_hi,
    input  logic [HW-1:0]  gpio_out_hi,
    input  logic [2:0]     gpio_dir_ctl,
    input  logic [2:0]     gpio_out_ctl,
    output logic [DW-1:0]  pad_ad_out,
    output logic [DW-1:0]  pad_ad_oe,
    output logic [HW-1:0]  pad_hi_out,
    output logic [HW-1:0]  pad_hi_oe,
    output logic           pad_ale,
    output logic           pad_rd_n,
    output logic           pad_wr_n,
    output logic [2:0]     pad_ctl_oe
);
    assign pad_ad_out = en ? seq_ad_out : gpio_out_ad;
    assign pad_ad_oe  = en ? {DW{seq_ad_oe}} : gpio_dir_ad;

    for (genvar i = 0; i < HW; i++) begin : g_hi
        logic owned;
        assign owned         = en && (hi_bits > HBW'(i));
        assign pad_hi_out[i] = owned ? seq_hi[i] : gpio_out_hi[i];
        assign pad_hi_oe[i]  = owned ? 1'b1 : gpio_dir_hi[i];
    end

    assign pad_ale    = en ? seq_ctl.ale  : gpio_out_ctl[0];
    assign pad_rd_n   = en ? seq_ctl.rd_n : gpio_out_ctl[1];
    assign pad_wr_n   = en ? seq_ctl.wr_n : gpio_out_ctl[2];
    assign pad_ctl_oe = en ? 3'b111 : gpio_dir_ctl;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int WSW       = 2,
    parameter int BOUND_RST = 'h21FF,
    localparam int HW       = AW - DW,
    localparam int HBW      = $clog2(HW + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_wr,
    input  logic           cfg_en,
    input  logic [HBW-1:0] cfg_hi_bits,
    input  logic [WSW-1:0] cfg_wait,
    input  logic [AW-1:0]  cfg_bound,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_wdata,
    output logic           cpu_ready,
    output logic [DW-1:0]  cpu_rdata,
    output logic           int_sel,
    output logic           int_we,
    output logic [AW-1:0]  int_addr,
    output logic [DW-1:0]  int_wdata,
    input  logic [DW-1:0]  int_rdata,
    input  logic [DW-1:0]  gpio_dir_ad,
    input  logic [DW-1:0]  gpio_out_ad,
    input  logic [HW-1:0]  gpio_dir_hi,
    input  logic [HW-1:0]  gpio_out_hi,
    input  logic [2:0]     gpio_dir_ctl,
    input  logic [2:0]     gpio_out_ctl,
    input  logic [DW-1:0]  pad_ad_in,
    output logic [DW-1:0]  pad_ad_out,
    output logic [DW-1:0]  pad_ad_oe,
    output logic [HW-1:0]  pad_hi_out,
    output logic [HW-1:0]  pad_hi_oe,
    output logic           pad_ale,
    output logic           pad_rd_n,
    output logic           pad_wr_n,
    output logic [2:0]     pad_ctl_oe
);
    logic           cfg_en_q;
    logic [HBW-1:0] cfg_hi_q;
    logic [WSW-1:0] cfg_wait_q;
    logic [AW-1:0]  cfg_bound_q;
    ctl_pins_t      seq_ctl;
    logic [DW-1:0]  seq_ad_out;
    logic           seq_ad_oe;
    logic [HW-1:0]  seq_hi;

    xbus_cfg #(.AW(AW), .HW(HW), .HBW(HBW), .WSW(WSW), .BOUND_RST(BOUND_RST)) u_cfg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en_i(cfg_en),
        .cfg_hi_i(cfg_hi_bits), .cfg_wait_i(cfg_wait), .cfg_bound_i(cfg_bound),
        .en_q(cfg_en_q), .hi_q(cfg_hi_q), .wait_q(cfg_wait_q), .bound_q(cfg_bound_q)
    );

    xbus_seq #(.AW(AW), .DW(DW), .WSW(WSW)) u_seq (
        .clk(clk), .rst(rst), .en(cfg_en_q), .wait_n(cfg_wait_q), .bound(cfg_bound_q),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .pad_ad_in(pad_ad_in),
        .int_rdata(int_rdata), .ctl(seq_ctl), .ad_out(seq_ad_out), .ad_oe(seq_ad_oe),
        .hi_addr(seq_hi), .int_sel(int_sel), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata)
    );

    xbus_pinmux #(.DW(DW), .HW(HW), .HBW(HBW)) u_pinmux (
        .en(cfg_en_q), .hi_bits(cfg_hi_q), .seq_ad_out(seq_ad_out), .seq_ad_oe(seq_ad_oe),
        .seq_hi(seq_hi), .seq_ctl(seq_ctl), .gpio_dir_ad(gpio_dir_ad),
        .gpio_out_ad(gpio_out_ad), .gpio_dir_hi(gpio_dir_hi), .gpio_out_hi(gpio_out_hi),
        .gpio_dir_ctl(gpio_dir_ctl), .gpio_out_ctl(gpio_out_ctl),
        .pad_ad_out(pad_ad_out), .pad_ad_oe(pad_ad_oe), .pad_hi_out(pad_hi_out),
        .pad_hi_oe(pad_hi_oe), .pad_ale(pad_ale), .pad_rd_n(pad_rd_n),
        .pad_wr_n(pad_wr_n), .pad_ctl_oe(pad_ctl_oe)
    );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_en_q,
    input logic          pad_ale,
    input logic          pad_rd_n,
    input logic          pad_wr_n,
    input logic [DW-1:0] pad_ad_out,
    input logic [DW-1:0] pad_ad_oe,
    input logic [2:0]    pad_ctl_oe,
    input logic [DW-1:0] gpio_dir_ad,
    input logic [2:0]    gpio_dir_ctl,
    input logic          int_sel,
    input logic          cpu_ready
);
    assert_no_strobe_in_ale_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_en_q && pad_ale) |-> (pad_rd_n && pad_wr_n));

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_en_q |-> (pad_rd_n || pad_wr_n));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_en_q && $past(cfg_en_q) && $fell(pad_ale))
            |-> (pad_ad_oe == {DW{1'b1}} && $stable(pad_ad_out)));

    assert_internal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_en_q && int_sel) |-> (pad_rd_n && pad_wr_n));

    assert_internal_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        int_sel |=> !int_sel);

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    assert_port_owned_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_en_q |-> (pad_ad_oe == gpio_dir_ad && pad_ctl_oe == gpio_dir_ctl));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .cfg_en_q(cfg_en_q), .pad_ale(pad_ale),
    .pad_rd_n(pad_rd_n), .pad_wr_n(pad_wr_n), .pad_ad_out(pad_ad_out),
    .pad_ad_oe(pad_ad_oe), .pad_ctl_oe(pad_ctl_oe), .gpio_dir_ad(gpio_dir_ad),
    .gpio_dir_ctl(gpio_dir_ctl), .int_sel(int_sel), .cpu_ready(cpu_ready)
);

// File: tb/xbus_ctrl_test.sv
`timescale 1ns/1ps
module xbus_ctrl_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_wr = 0, cfg_en = 0;
    logic [3:0]  cfg_hi_bits = 0;
    logic [1:0]  cfg_wait = 0;
    logic [15:0] cfg_bound = 0;
    logic        cpu_req = 0, cpu_we = 0;
    logic [15:0] cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        int_sel, int_we;
    logic [15:0] int_addr;
    logic [7:0]  int_wdata, int_rdata;
    logic [7:0]  gpio_dir_ad = 8'h0F, gpio_out_ad = 8'hA5;
    logic [7:0]  gpio_dir_hi = 8'h33, gpio_out_hi = 8'hC3;
    logic [2:0]  gpio_dir_ctl = 3'b011, gpio_out_ctl = 3'b110;
    logic [7:0]  pad_ad_in, pad_ad_out, pad_ad_oe, pad_hi_out, pad_hi_oe;
    logic        pad_ale, pad_rd_n, pad_wr_n;
    logic [2:0]  pad_ctl_oe;
    logic [7:0]  lat_lo = 0;

    int tests = 0, fails = 0;
    logic        cur_en = 0;
    logic [1:0]  cur_wait = 0;
    logic [15:0] cur_bound = 16'h21FF;

    always #4 clk = ~clk;

    xbus_ctrl uut (.*);

    function automatic logic [7:0] ext_data(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] int_data(input logic [15:0] a);
        return ~a[7:0] ^ a[15:8];
    endfunction

    always @(pad_ale or pad_ad_out) if (pad_ale) lat_lo = pad_ad_out;
    assign pad_ad_in = ext_data({pad_hi_out, lat_lo});
    assign int_rdata = int_data(int_addr);

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic pins_are_gpio();
        return pad_ad_oe == gpio_dir_ad && pad_ad_out == gpio_out_ad &&
               pad_hi_oe == gpio_dir_hi && pad_hi_out == gpio_out_hi &&
               pad_ctl_oe == gpio_dir_ctl &&
               {pad_wr_n, pad_rd_n, pad_ale} == gpio_out_ctl;
    endfunction

    task automatic cfg_write(input logic en, input logic [3:0] hi, input logic [1:0] w,
                             input logic [15:0] b);
        @(negedge clk);
        cfg_wr = 1; cfg_en = en; cfg_hi_bits = hi; cfg_wait = w; cfg_bound = b;
        @(negedge clk);
        cfg_wr = 0;
        cur_en = en; cur_wait = w; cur_bound = b;
    endtask

    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] wd,
                          input bit poke);
        logic ext;
        int exp_lat, n, ale_c, rd_c, wr_c, is_c;
        logic hold_bad, rd_bad, wr_bad, is_bad, pins_bad, prev_ale;
        logic [7:0] prev_ad, ad_ale, hi_ale;
        logic [15:0] wa;
        ext = a > cur_bound;
        exp_lat = cur_en ? (ext ? 4 + int'(cur_wait) : 4) : (ext ? 1 : 2);
        ale_c = 0; rd_c = 0; wr_c = 0; is_c = 0;
        hold_bad = 0; rd_bad = 0; wr_bad = 0; is_bad = 0; pins_bad = 0; prev_ale = 0;
        prev_ad = 0; ad_ale = 0; hi_ale = 0; wa = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0; n = 1;
        while (!cpu_ready && n < 60) begin
            if (pad_ale) begin
                ale_c++; ad_ale = pad_ad_out; hi_ale = pad_hi_out;
                if (pad_ad_oe != 8'hFF) hold_bad = 1;
            end
            if (cur_en && prev_ale && !pad_ale &&
                (pad_ad_oe != 8'hFF || pad_ad_out != prev_ad)) hold_bad = 1;
            if (!pad_rd_n) begin
                rd_c++;
                if (pad_ad_oe != 8'h00) rd_bad = 1;
            end
            if (!pad_wr_n) begin
                wr_c++; wa = {pad_hi_out, lat_lo};
                if (pad_ad_oe != 8'hFF || pad_ad_out != wd) wr_bad = 1;
            end
            if (int_sel) begin
                is_c++;
                if (int_addr != a || int_we != we) is_bad = 1;
                if (cur_en && (pad_ad_oe != 8'hFF ||
                               pad_ad_out != (we ? wd : int_data(a)))) is_bad = 1;
            end
            if (!cur_en && !pins_are_gpio()) pins_bad = 1;
            prev_ale = pad_ale; prev_ad = pad_ad_out;
            if (poke && n == 2) begin
                cpu_req = 1; cpu_addr = a ^ 16'h0101; cpu_we = ~we;
            end else begin
                cpu_req = 0;
            end
            @(negedge clk);
            n++;
        end
        cpu_req = 0;
        chk("R8", "latency", n, exp_lat);
        if (!we) chk(ext ? (cur_en ? "R7" : "R10") : "R11", "read data", cpu_rdata,
                     ext ? (cur_en ? ext_data(a) : 8'h00) : int_data(a));
        if (cur_en) begin
            chk("R4", "ale cycles", ale_c, 1);
            chk("R4", "low addr at ale", ad_ale, a[7:0]);
            chk("R4", "high addr at ale", hi_ale, a[15:8]);
            chk("R4", "addr held after ale", hold_bad, 0);
        end else begin
            chk("R2", "pins follow port", pins_bad, 0);
        end
        if (cur_en && ext) begin
            chk("R5", "read strobe cycles", rd_c, we ? 0 : int'(cur_wait) + 1);
            chk("R5", "write strobe cycles", wr_c, we ? int'(cur_wait) + 1 : 0);
            chk("R7", "bus released during read", rd_bad, 0);
            chk("R6", "write data on bus", wr_bad, 0);
            if (we) chk("R6", "latched write addr", wa, a);
        end else begin
            chk("R9", "no strobes", rd_c + wr_c, 0);
        end
        chk("R3", "internal select cycles", is_c, ext ? 0 : 1);
        chk("R9", "internal select fields", is_bad, 0);
        @(negedge clk);
        chk("R8", "ready single pulse", cpu_ready, 0);
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                chk("R13", "no second access", {pad_ale, cpu_ready, int_sel}, 3'b000);
                @(negedge clk);
            end
        end
    endtask

    function automatic logic [15:0] pick(input int i, input int w);
        case (i)
            0: return 16'h2200;
            1: return 16'hFFFF;
            2: return 16'h8A3C ^ 16'(w * 16'h0111);
            3: return 16'h21FF;
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: cycles=100000 expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", "ready after reset", cpu_ready, 0);
        chk("R1", "pins after reset", pins_are_gpio(), 1);

        // disabled
        access(0, 16'h0100, 8'h00, 0);
        access(0, 16'h3000, 8'h00, 0);
        access(1, 16'hFF00, 8'h77, 0);
        access(1, 16'h0010, 8'h99, 0);

        for (int w = 0; w < 4; w++) begin
            cfg_write(1, 4'd8, 2'(w), 16'h21FF);
            for (int i = 0; i < 5; i++) begin
                access(0, pick(i, w), 8'h00, 0);
                access(1, pick(i, w), 8'(8'h5A + w * 17 + i), 0);
            end
        end

        access(0, 16'h4321, 8'h00, 1);

        cfg_write(1, 4'd8, 2'd1, 16'h00FF);
        access(0, 16'h0100, 8'h00, 0);
        access(0, 16'h00FF, 8'h00, 0);
        access(0, 16'hB6C1, 8'h00, 0);

        for (int k = 0; k < 10; k++) begin
            logic [7:0] m;
            cfg_write(1, 4'(k), 2'd0, 16'h00FF);
            m = 8'((9'h1 << (k > 8 ? 8 : k)) - 9'h1);
            chk("R12", "high pin enables", pad_hi_oe, m | (gpio_dir_hi & ~m));
            chk("R12", "high pin values", pad_hi_out, (8'hB6 & m) | (gpio_out_hi & ~m));
        end

        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        cur_en = 0; cur_bound = 16'h21FF;
        @(negedge clk);
        chk("R1", "enable cleared by reset", pins_are_gpio(), 1);
        access(0, 16'h5000, 8'h00, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule